// File: doc/BRIEF.md
# Metastability Delay Effects Injector

This block stands in for the receive-side capture register of a multi-bit clock-domain crossing during simulation. It shows the timing effects that metastability can have in silicon, so that logic which relies on several crossing bits arriving together is exposed. Every bit of the bus passes through a short receive pipeline. When injection is off, each bit arrives with a fixed two-cycle latency. When injection is on and a capture is physically risky, each bit on its own may instead arrive one receive cycle late, which models a setup failure, or one receive cycle early, which models hold bleed-through. The decision is pseudo-random.

A capture counts as risky only in one case: a transmit-side update has just changed that bit, and the receive register is being loaded in the same cycle. The random stream comes from a 32-bit LFSR whose start value is read from a port at reset. Different seeds therefore give different injection patterns from the same test.

Top module: `cdc_meta_injector`

## Requirements
- R1: While `inj_en` is low, every bit of `rx_data` equals the `tx_data` bit captured two rising edges of `clk` earlier.
- R2: A rising edge of `clk` with `rst_n` low clears all pipeline stages, change flags and delay state, so `rx_data` reads 0 after reset. The same edge loads the LFSR from `seed`, or from 32'h1D87_2B41 when `seed` is zero. `seed` has no effect at any other time.
- R3: Outside reset, the LFSR advances on every clock edge, whatever the other inputs are. The step is a right shift, and the result is XORed with 32'h8020_0003 when the bit shifted out was 1.
- R4: A change flag for bit i is set at an edge where `tx_upd` is high and `tx_data[i]` differs from the value captured at the previous edge. The flag lasts one cycle. Bit i is eligible in that cycle only when its flag, `rx_load` and `inj_en` are all high.
- R5: The outcome for bit i is read from LFSR bits [2i+1:2i] in the eligible cycle. 2'b01 selects delayed, 2'b10 selects advanced, and 2'b00 or 2'b11 select nominal.
- R6: An advanced outcome makes bit i show its newest captured value in the eligible cycle itself, which is one cycle earlier than nominal.
- R7: A delayed outcome makes bit i show, in the following cycle only, the value captured three edges earlier, provided `inj_en` is still high then.
- R8: Bits resolve independently, so bits of one bus can take different outcomes in the same cycle.
- R9: An advanced outcome is suppressed when bit i is delayed in the current cycle or was delayed in the previous cycle. As a result, no bit value that stays stable for two or more captures is ever skipped.
- R10: A change of `tx_data` without `tx_upd` sets no flag and therefore causes no injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed | input | 32 | LFSR start value, sampled during reset |
| tx_data | input | WIDTH | Transmit-domain register value |
| tx_upd | input | 1 | Transmit update strobe, seen in the receive domain |
| rx_load | input | 1 | Receive register load enable |
| inj_en | input | 1 | Enables delay/advance injection |
| rx_data | output | WIDTH | Receive value with injected timing effects |

## Verification
Nominal data appears at `rx_data` two edges after it is driven. An advanced bit appears in the same cycle as its flag, which is one edge after capture. A delayed bit shows the old value in the cycle after its flag. The bench drives all inputs just after the falling edge and compares `rx_data` one time unit later, against a cycle model stepped once per rising edge. Each comparison therefore sees exactly the register state that the preceding edges produced. The R1 phase also compares each output against the bench's own record of the stimulus from two cycles earlier, independently of the model.

// File: rtl/cdc_meta_pkg.sv
package cdc_meta_pkg;

   localparam int unsigned RNG_W = 32;
   localparam logic [RNG_W-1:0] RNG_TAPS = 32'h8020_0003;
   localparam logic [RNG_W-1:0] RNG_FALLBACK = 32'h1D87_2B41;

   // outcome code taken from two generator bits
   typedef enum logic [1:0] {
      PICK_NOM_LO = 2'b00,
      PICK_LATE   = 2'b01,
      PICK_EARLY  = 2'b10,
      PICK_NOM_HI = 2'b11
   } pick_e;

   function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
      return {1'b0, s[RNG_W-1:1]} ^ (s[0] ? RNG_TAPS : '0);
   endfunction

endpackage

// File: rtl/meta_rng.sv
module meta_rng
   import cdc_meta_pkg::*;
#(
   parameter int unsigned W = RNG_W,
   parameter logic [W-1:0] FALLBACK = RNG_FALLBACK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] seed,
   output logic [W-1:0] state
);

   generate
      if (W != RNG_W) begin : g_bad_w
         $error("meta_rng: only a %0d-bit generator is supported", RNG_W);
      end
      if (FALLBACK == '0) begin : g_bad_fb
         $error("meta_rng: fallback seed must be nonzero");
      end
   endgenerate

   logic [W-1:0] start_val;
   assign start_val = (seed == '0) ? FALLBACK : seed;

   always_ff @(posedge clk) begin
      if (!rst_n) state <= start_val;
      else        state <= rng_step(state);
   end

   // R3
   rng_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

   // R3
   rng_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> state == rng_step($past(state)));

endmodule

// File: rtl/meta_bit_lane.sv
module meta_bit_lane
   import cdc_meta_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_bit,
   input  logic       tx_upd,
   input  logic       rx_load,
   input  logic       inj_en,
   input  logic [1:0] pick,
   output logic       rx_bit
);

   // capture pipeline: stage1 newest, stage3 oldest
   logic st1, st2, st3;
   logic chg_flag;
   logic late_q;
   logic was_late;

   logic eligible;
   logic late_req;
   logic late_now;
   logic early_now;

   assign eligible  = inj_en & rx_load & chg_flag;
   assign late_req  = eligible & (pick_e'(pick) == PICK_LATE);
   assign late_now  = late_q & inj_en;
   assign early_now = eligible & (pick_e'(pick) == PICK_EARLY) & ~late_q & ~was_late;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st1      <= 1'b0;
         st2      <= 1'b0;
         st3      <= 1'b0;
         chg_flag <= 1'b0;
         late_q   <= 1'b0;
         was_late <= 1'b0;
      end else begin
         st1      <= tx_bit;
         st2      <= st1;
         st3      <= st2;
         chg_flag <= tx_upd & (tx_bit ^ st1);
         late_q   <= late_req;
         was_late <= late_now;
      end
   end

   always_comb begin
      if (late_now)       rx_bit = st3;
      else if (early_now) rx_bit = st1;
      else                rx_bit = st2;
   end

   // R1
   off_is_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_en |-> rx_bit == st2);

   // R7
   late_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      late_q |-> $past(chg_flag && rx_load && inj_en));

   // R6
   early_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bit != st2 && !late_q) |-> (chg_flag && rx_load && inj_en));

   // R9
   no_skip_after_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (was_late && !late_q) |-> rx_bit == st2);

endmodule

// File: rtl/cdc_meta_injector.sv
module cdc_meta_injector
   import cdc_meta_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter logic [RNG_W-1:0] FALLBACK = RNG_FALLBACK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RNG_W-1:0] seed,
   input  logic [WIDTH-1:0] tx_data,
   input  logic             tx_upd,
   input  logic             rx_load,
   input  logic             inj_en,
   output logic [WIDTH-1:0] rx_data
);

   localparam int unsigned PICK_BITS = 2 * WIDTH;

   generate
      if (WIDTH == 0 || PICK_BITS > RNG_W) begin : g_bad_width
         $error("cdc_meta_injector: WIDTH must be 1..%0d", RNG_W / 2);
      end
   endgenerate

   logic [RNG_W-1:0] rng_state;

   meta_rng #(
      .W        (RNG_W),
      .FALLBACK (FALLBACK)
   ) rng_i (
      .clk   (clk),
      .rst_n (rst_n),
      .seed  (seed),
      .state (rng_state)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      meta_bit_lane lane_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .tx_bit  (tx_data[i]),
         .tx_upd  (tx_upd),
         .rx_load (rx_load),
         .inj_en  (inj_en),
         .pick    (rng_state[2*i +: 2]),
         .rx_bit  (rx_data[i])
      );
   end

   // R2
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> rx_data == '0);

endmodule

// File: tb/cdc_meta_injector_tb_top.sv
module cdc_meta_injector_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam logic [31:0] FB = 32'h1D87_2B41;
   localparam logic [31:0] TAPS = 32'h8020_0003;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   seed = 32'h0BAD_F00D;
   logic [W-1:0]  tx_data = '0;
   logic          tx_upd = 1'b0;
   logic          rx_load = 1'b0;
   logic          inj_en = 1'b0;
   logic [W-1:0]  rx_data;

   int n_checks = 0;
   int n_fail = 0;
   int n_early = 0;
   int n_late = 0;
   int n_mixed = 0;

   // bench cycle model state
   logic [W-1:0] m1, m2, m3, mflag, mlate, mwas;
   logic [31:0]  mrng;
   logic [W-1:0] hist1, hist2;

   always #(CLK_PERIOD/2) clk = ~clk;

   cdc_meta_injector #(.WIDTH(W)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .seed    (seed),
      .tx_data (tx_data),
      .tx_upd  (tx_upd),
      .rx_load (rx_load),
      .inj_en  (inj_en),
      .rx_data (rx_data)
   );

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] r;
      r = s >> 1;
      if (s[0]) r = r ^ TAPS;
      return r;
   endfunction

   function automatic logic [1:0] code_of(input int i);
      return mrng[2*i +: 2];
   endfunction

   function automatic logic [W-1:0] expect_out();
      logic [W-1:0] e;
      for (int i = 0; i < W; i++) begin
         logic elig, early;
         elig  = inj_en & rx_load & mflag[i];
         early = elig & (code_of(i) == 2'b10) & ~mlate[i] & ~mwas[i];
         if (mlate[i] & inj_en) e[i] = m3[i];
         else if (early)        e[i] = m1[i];
         else                   e[i] = m2[i];
      end
      return e;
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         m1 = '0; m2 = '0; m3 = '0; mflag = '0; mlate = '0; mwas = '0;
         mrng = (seed == 0) ? FB : seed;
      end else begin
         logic [W-1:0] nlate, nwas, ne;
         int ne_cnt, nn_cnt;
         ne_cnt = 0; nn_cnt = 0;
         for (int i = 0; i < W; i++) begin
            logic elig;
            elig = inj_en & rx_load & mflag[i];
            nlate[i] = elig & (code_of(i) == 2'b01);
            nwas[i]  = mlate[i] & inj_en;
            ne[i]    = elig & (code_of(i) == 2'b10) & ~mlate[i] & ~mwas[i];
            if (ne[i]) begin n_early++; ne_cnt++; end
            if (nlate[i]) n_late++;
            if (elig && !ne[i]) nn_cnt++;
         end
         if (ne_cnt > 0 && nn_cnt > 0) n_mixed++;
         mlate = nlate;
         mwas  = nwas;
         mflag = tx_upd ? (tx_data ^ m1) : '0;
         m3 = m2; m2 = m1; m1 = tx_data;
         mrng = next_rng(mrng);
      end
      hist2 = hist1;
      hist1 = tx_data;
   endtask

   task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive after falling edge, compare, then account for the rising edge
   task automatic cycle(input logic [W-1:0] d, input logic upd, input logic ld, input logic inj, input string req);
      @(negedge clk);
      tx_data = d; tx_upd = upd; rx_load = ld; inj_en = inj;
      #1;
      if (rst_n) begin
         logic [W-1:0] e;
         e = expect_out();
         check(rx_data === e, req, rx_data, e);
      end
      model_edge();
   endtask

   task automatic do_reset(input logic [31:0] s);
      @(negedge clk);
      rst_n = 1'b0; seed = s;
      model_edge();
      for (int k = 0; k < 3; k++) cycle(tx_data, 1'b0, 1'b0, 1'b0, "R2");
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R2: outputs cleared after reset
      check(rx_data === '0, "R2", rx_data, '0);
      model_edge();
   endtask

   // random bus run; pchg: percent of cycles the bus changes
   task automatic random_run(input int n, input int pchg, input bit use_upd, input bit ld_on, input bit inj, input string req);
      logic [W-1:0] d;
      d = tx_data;
      for (int k = 0; k < n; k++) begin
         logic upd, ld;
         upd = 1'b0;
         if (($urandom % 100) < pchg) begin
            d = d ^ W'($urandom);
            upd = use_upd;
         end else if (use_upd && ($urandom % 8) == 0) begin
            upd = 1'b1;
         end
         ld = ld_on ? (($urandom % 8) != 0) : 1'b0;
         if (($urandom % 50) == 0) seed = $urandom;  // R2: ignored outside reset
         cycle(d, upd, ld, inj, req);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      hist1 = '0; hist2 = '0;
      do_reset(32'h0BAD_F00D);

      // R1: injection off, compare against two-cycle history directly
      for (int k = 0; k < 300; k++) begin
         logic [W-1:0] d;
         d = (k % 3 == 0) ? W'($urandom) : tx_data;
         @(negedge clk);
         tx_data = d; tx_upd = 1'b1; rx_load = 1'b1; inj_en = 1'b0;
         #1;
         check(rx_data === hist2, "R1", rx_data, hist2);
         model_edge();
      end

      // R10: bus changes without strobe, injection on
      random_run(400, 60, 1'b0, 1'b1, 1'b1, "R10");
      // R4: strobe with changes but receive load low
      random_run(400, 60, 1'b1, 1'b0, 1'b1, "R4");
      // R5 R6 R7 R8 R9 R3: full random with injection
      random_run(3000, 40, 1'b1, 1'b1, 1'b1, "R5 R6 R7 R9 R3");
      // R9: fast toggling, values stable one or two cycles
      random_run(1500, 70, 1'b1, 1'b1, 1'b1, "R9");
      // R7: injection switched off while a delay is pending
      for (int k = 0; k < 600; k++) begin
         cycle(tx_data ^ W'($urandom), 1'b1, 1'b1, (k % 2) == 0, "R7");
      end
      // R6 R7 R8 coverage of outcomes
      check(n_early > 0, "R6", W'(n_early), W'(1));
      check(n_late > 0, "R7", W'(n_late), W'(1));
      check(n_mixed > 0, "R8", W'(n_mixed), W'(1));

      // R2: zero seed uses the fallback constant
      do_reset(32'h0);
      random_run(1500, 40, 1'b1, 1'b1, 1'b1, "R2 zero seed");
      // R2: a different seed gives its own pattern
      do_reset(32'h1357_9BDF);
      random_run(1000, 40, 1'b1, 1'b1, 1'b1, "R2 R3 seed");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule